// File: doc/BRIEF.md
# Serial Target for a Shared Analog and General-Purpose Pin Bank

This block is the serial-port front of a 32-pin device in which every pin can be used either as an analog input or as a general-purpose pin. The port runs SPI mode 0 with 16-bit frames. Each frame is bounded by chip select. The first byte of a frame is a command, and one bit of that command chooses between two address spaces. One is a conversion channel number. The other is a small register bank that holds, for every pin, an input enable, an output enable and an output level.

A write takes one frame. A read takes two frames, with chip select released between them. The first frame names what is wanted. During the second frame the block shifts the answer out on MISO. It ignores whatever the controller sends on MOSI during that second frame. The answer is either a register byte or a 12-bit conversion word. The conversion word carries a flag that is set when the chosen pin is currently assigned to general-purpose use.

A parallel port supplies one stub conversion value per channel and the 32 raw pin levels. The block drives the output-enable and output-level vectors toward the pads. The serial inputs are resampled in the system clock domain, so SCLK must be slow compared with the system clock.

Top module: `spi_mux_target`

## Requirements
- R1: After reset every enable and output-level register is zero, `pin_oe` and `pin_out` are zero, and MISO is low.
- R2: A complete frame whose command byte is 0x20 plus an offset (bits 15..14 = 00, bit 13 = 1, bit 12 = 0, offset in bits 11..8) writes its low byte to that register. Offsets 4..7 hold input enables, 8..11 hold output enables driven on `pin_oe`, and 12..15 hold output levels driven on `pin_out`.
- R3: Inside each group of four offsets, the two low offset bits select the pins: 0 selects pins 24..31, 1 selects 16..23, 2 selects 8..15 and 3 selects 0..7. Register bit k maps to the lowest pin of that range plus k.
- R4: A frame with command byte 0x30 plus an offset requests a register read. The next complete frame returns 0x00 followed by the register byte, MSB first.
- R5: Offsets 0..3 are read-only. They read as the synchronised pin level ANDed with the input-enable bit. Writes to them change nothing.
- R6: A frame with bit 13 = 0 requests a conversion of the channel in bits 12..8. The next complete frame returns bit 15 = 0, bit 14 = status flag, bits 13..12 = 0 and bits 11..0 = the channel's result.
- R7: Channel n takes its result from the n-th 12-bit slot of `adc_result` (slot n at bits 12n+11..12n). Channels 0..15 are pins 0..15 (bank A) and channels 16..31 are pins 16..31 (bank B).
- R8: The status flag is 1 exactly when the channel's input-enable or output-enable bit is set.
- R9: A frame that ends with any SCLK rising-edge count other than 16 is dropped. It makes no write, and a pending read stays pending until a complete frame arrives.
- R10: The complete frame that follows a read request carries the answer. Its MOSI content is never decoded, so it causes no write and no new request.
- R11: MISO stays low while chip select is inactive and during any frame for which no read is pending.
- R12: A complete frame with bit 15 or bit 14 set is ignored: no write and no request.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| spi_sclk | input | 1 | Serial clock, idle low |
| spi_cs_n | input | 1 | Chip select, active low |
| spi_mosi | input | 1 | Controller-to-target data |
| spi_miso | output | 1 | Target-to-controller data |
| adc_result | input | 384 | 32 stub conversion results, 12 bits each, channel 0 in the low slot |
| pin_in | input | 32 | Raw pin levels |
| pin_out | output | 32 | Output levels for the pins |
| pin_oe | output | 32 | Output enables for the pins |

## Verification
The checker assumes that chip select stays inactive for at least two system clocks between frames. It also assumes that SCLK and MOSI hold each level for several system clocks, so that each serial edge is seen once after resampling. The bench meets these assumptions by holding every SCLK phase for ten system clocks, leaving twelve idle clocks after each frame, and changing MOSI only while SCLK is low. All serial inputs are changed on the falling system-clock edge, and `pin_in` is set well before any read that depends on it.

// File: rtl/smx_pkg.sv
package smx_pkg;

   localparam int CMD_OFS_W = 4;
   localparam int CH_W      = 5;
   localparam int LANE_W    = 8;

   typedef enum logic [1:0] {
      RQ_NONE = 2'd0,
      RQ_REG  = 2'd1,
      RQ_ADC  = 2'd2
   } rq_kind_e;

   typedef struct packed {
      rq_kind_e          kind;
      logic [CH_W-1:0]   idx;
   } rq_t;

   typedef enum logic [1:0] {
      GRP_IN_LVL = 2'd0,
      GRP_IN_EN  = 2'd1,
      GRP_OUT_EN = 2'd2,
      GRP_OUT_LV = 2'd3
   } reg_grp_e;

endpackage

// File: rtl/smx_sync.sv
module smx_sync #(
   parameter int          W       = 1,
   parameter int          STAGES  = 2,
   parameter logic [W-1:0] RST_VAL = '0
) (
   input  logic         clk,
   input  logic         rst_n,
   input  logic [W-1:0] d,
   output logic [W-1:0] q
);

   if (STAGES < 0) begin : g_bad_stages
      $error("smx_sync: STAGES must not be negative");
   end

   if (STAGES == 0) begin : g_bypass
      assign q = d;
   end else begin : g_chain
      logic [W-1:0] stg [STAGES];
      always_ff @(posedge clk or negedge rst_n) begin
         if (!rst_n) begin
            for (int i = 0; i < STAGES; i++) stg[i] <= RST_VAL;
         end else begin
            stg[0] <= d;
            for (int i = 1; i < STAGES; i++) stg[i] <= stg[i-1];
         end
      end
      assign q = stg[STAGES-1];
   end

endmodule

// File: rtl/smx_frame_rx.sv
module smx_frame_rx #(
   parameter int FRAME_W = 16
) (
   input  logic               clk,
   input  logic               rst_n,
   input  logic               sclk_s,
   input  logic               cs_n_s,
   input  logic               mosi_s,
   output logic               sel_start,
   output logic               sel_end,
   output logic               bit_fall,
   output logic               frame_done,
   output logic [FRAME_W-1:0] frame_word
);

   localparam int CNT_W = $clog2(FRAME_W + 2);
   localparam logic [CNT_W-1:0] FULL_CNT = CNT_W'(FRAME_W);

   logic               sclk_d, cs_n_d;
   logic [CNT_W-1:0]   bit_cnt;
   logic [FRAME_W-1:0] rx_sh;
   logic               bit_rise;

   assign sel_start = cs_n_d & ~cs_n_s;
   assign sel_end   = ~cs_n_d & cs_n_s;
   assign bit_rise  = ~cs_n_s & ~sclk_d & sclk_s;
   assign bit_fall  = ~cs_n_s & sclk_d & ~sclk_s;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         sclk_d     <= 1'b0;
         cs_n_d     <= 1'b1;
         bit_cnt    <= '0;
         rx_sh      <= '0;
         frame_done <= 1'b0;
         frame_word <= '0;
      end else begin
         sclk_d     <= sclk_s;
         cs_n_d     <= cs_n_s;
         frame_done <= 1'b0;
         if (sel_start) begin
            bit_cnt <= '0;
         end else if (bit_rise) begin
            rx_sh <= {rx_sh[FRAME_W-2:0], mosi_s};
            if (bit_cnt != '1) bit_cnt <= bit_cnt + 1'b1;
         end
         if (sel_end && bit_cnt == FULL_CNT) begin
            frame_done <= 1'b1;
            frame_word <= rx_sh;
         end
      end
   end

endmodule

// File: rtl/smx_cmd_ctrl.sv
module smx_cmd_ctrl
   import smx_pkg::*;
#(
   parameter int FRAME_W = 16
) (
   input  logic                  clk,
   input  logic                  rst_n,
   input  logic                  frame_done,
   input  logic [FRAME_W-1:0]    frame_word,
   output logic                  wr_en,
   output logic [CMD_OFS_W-1:0]  wr_ofs,
   output logic [LANE_W-1:0]     wr_data,
   output rq_t                   rq
);

   localparam int CMD_HI = FRAME_W - 1;

   logic              hdr_bad;
   logic              io_sel;
   logic              rd_bit;
   logic [CH_W-1:0]   chan;

   assign hdr_bad = frame_word[CMD_HI] | frame_word[CMD_HI-1];
   assign io_sel  = frame_word[CMD_HI-2];
   assign rd_bit  = frame_word[CMD_HI-3];
   assign chan    = frame_word[CMD_HI-3 -: CH_W];

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         wr_en   <= 1'b0;
         wr_ofs  <= '0;
         wr_data <= '0;
         rq      <= '{kind: RQ_NONE, idx: '0};
      end else begin
         wr_en <= 1'b0;
         if (frame_done) begin
            if (rq.kind != RQ_NONE) begin
               rq.kind <= RQ_NONE;
            end else if (!hdr_bad) begin
               if (!io_sel) begin
                  rq <= '{kind: RQ_ADC, idx: chan};
               end else if (rd_bit) begin
                  rq <= '{kind: RQ_REG, idx: {1'b0, chan[CMD_OFS_W-1:0]}};
               end else begin
                  wr_en   <= 1'b1;
                  wr_ofs  <= chan[CMD_OFS_W-1:0];
                  wr_data <= frame_word[LANE_W-1:0];
               end
            end
         end
      end
   end

endmodule

// File: rtl/smx_regbank.sv
module smx_regbank
   import smx_pkg::*;
#(
   parameter int NUM_PINS = 32
) (
   input  logic                 clk,
   input  logic                 rst_n,
   input  logic                 wr_en,
   input  logic [CMD_OFS_W-1:0] wr_ofs,
   input  logic [LANE_W-1:0]    wr_data,
   input  logic [CMD_OFS_W-1:0] rd_ofs,
   input  logic [NUM_PINS-1:0]  pin_lvl,
   output logic [LANE_W-1:0]    rd_data,
   output logic [NUM_PINS-1:0]  in_en,
   output logic [NUM_PINS-1:0]  out_en,
   output logic [NUM_PINS-1:0]  out_lv
);

   localparam int LANES = NUM_PINS / LANE_W;

   logic [NUM_PINS-1:0] in_vis;

   for (genvar L = 0; L < LANES; L++) begin : g_lane
      localparam logic [1:0] SEL = 2'(LANES - 1 - L);
      logic [LANE_W-1:0] in_en_q, out_en_q, out_lv_q;
      logic              hit;

      assign hit = wr_en && (wr_ofs[1:0] == SEL);

      always_ff @(posedge clk or negedge rst_n) begin
         if (!rst_n) begin
            in_en_q  <= '0;
            out_en_q <= '0;
            out_lv_q <= '0;
         end else if (hit) begin
            case (reg_grp_e'(wr_ofs[3:2]))
               GRP_IN_EN:  in_en_q  <= wr_data;
               GRP_OUT_EN: out_en_q <= wr_data;
               GRP_OUT_LV: out_lv_q <= wr_data;
               default:    ;
            endcase
         end
      end

      assign in_en [L*LANE_W +: LANE_W] = in_en_q;
      assign out_en[L*LANE_W +: LANE_W] = out_en_q;
      assign out_lv[L*LANE_W +: LANE_W] = out_lv_q;
   end

   assign in_vis = pin_lvl & in_en;

   always_comb begin
      logic [1:0] lane;
      lane = 2'(LANES - 1) - rd_ofs[1:0];
      case (reg_grp_e'(rd_ofs[3:2]))
         GRP_IN_LVL: rd_data = in_vis[lane*LANE_W +: LANE_W];
         GRP_IN_EN:  rd_data = in_en [lane*LANE_W +: LANE_W];
         GRP_OUT_EN: rd_data = out_en[lane*LANE_W +: LANE_W];
         default:    rd_data = out_lv[lane*LANE_W +: LANE_W];
      endcase
   end

endmodule

// File: rtl/smx_tx.sv
module smx_tx #(
   parameter int FRAME_W = 16
) (
   input  logic               clk,
   input  logic               rst_n,
   input  logic               load,
   input  logic [FRAME_W-1:0] load_word,
   input  logic               shift,
   input  logic               clear,
   output logic               miso
);

   logic [FRAME_W-1:0] tx_sh;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         tx_sh <= '0;
      end else if (clear) begin
         tx_sh <= '0;
      end else if (load) begin
         tx_sh <= load_word;
      end else if (shift) begin
         tx_sh <= {tx_sh[FRAME_W-2:0], 1'b0};
      end
   end

   assign miso = tx_sh[FRAME_W-1];

endmodule

// File: rtl/spi_mux_target.sv
module spi_mux_target
   import smx_pkg::*;
#(
   parameter int NUM_PINS    = 32,
   parameter int ADC_BITS    = 12,
   parameter int FRAME_W     = 16,
   parameter int SYNC_STAGES = 2
) (
   input  logic                         clk,
   input  logic                         rst_n,
   input  logic                         spi_sclk,
   input  logic                         spi_cs_n,
   input  logic                         spi_mosi,
   output logic                         spi_miso,
   input  logic [NUM_PINS*ADC_BITS-1:0] adc_result,
   input  logic [NUM_PINS-1:0]          pin_in,
   output logic [NUM_PINS-1:0]          pin_out,
   output logic [NUM_PINS-1:0]          pin_oe
);

   localparam int FLAG_POS = FRAME_W - 2;

   if (NUM_PINS != (1 << CH_W)) begin : g_bad_pins
      $error("spi_mux_target: NUM_PINS must match the 5-bit channel field");
   end
   if (FRAME_W != 16) begin : g_bad_frame
      $error("spi_mux_target: command layout needs 16-bit frames");
   end
   if (ADC_BITS > FRAME_W - 4) begin : g_bad_adc
      $error("spi_mux_target: result too wide for the answer frame");
   end

   logic                       sclk_s, cs_n_s, mosi_s;
   logic [NUM_PINS-1:0]        pin_lvl;
   logic                       sel_start, sel_end, bit_fall;
   logic                       frame_done;
   logic [FRAME_W-1:0]         frame_word;
   logic                       wr_en;
   logic [CMD_OFS_W-1:0]       wr_ofs;
   logic [LANE_W-1:0]          wr_data;
   rq_t                        rq;
   logic                       rq_busy;
   logic [LANE_W-1:0]          rd_data;
   logic [NUM_PINS-1:0]        in_en, out_en, out_lv;
   logic [ADC_BITS-1:0]        adc_arr [NUM_PINS];
   logic                       chan_flag;
   logic [FRAME_W-1:0]         rsp_word;

   smx_sync #(.W(3), .STAGES(SYNC_STAGES), .RST_VAL(3'b010)) u_ser_sync (
      .clk   (clk),
      .rst_n (rst_n),
      .d     ({spi_sclk, spi_cs_n, spi_mosi}),
      .q     ({sclk_s, cs_n_s, mosi_s})
   );

   smx_sync #(.W(NUM_PINS), .STAGES(SYNC_STAGES), .RST_VAL('0)) u_pin_sync (
      .clk   (clk),
      .rst_n (rst_n),
      .d     (pin_in),
      .q     (pin_lvl)
   );

   smx_frame_rx #(.FRAME_W(FRAME_W)) u_rx (
      .clk        (clk),
      .rst_n      (rst_n),
      .sclk_s     (sclk_s),
      .cs_n_s     (cs_n_s),
      .mosi_s     (mosi_s),
      .sel_start  (sel_start),
      .sel_end    (sel_end),
      .bit_fall   (bit_fall),
      .frame_done (frame_done),
      .frame_word (frame_word)
   );

   smx_cmd_ctrl #(.FRAME_W(FRAME_W)) u_ctrl (
      .clk        (clk),
      .rst_n      (rst_n),
      .frame_done (frame_done),
      .frame_word (frame_word),
      .wr_en      (wr_en),
      .wr_ofs     (wr_ofs),
      .wr_data    (wr_data),
      .rq         (rq)
   );

   smx_regbank #(.NUM_PINS(NUM_PINS)) u_regs (
      .clk     (clk),
      .rst_n   (rst_n),
      .wr_en   (wr_en),
      .wr_ofs  (wr_ofs),
      .wr_data (wr_data),
      .rd_ofs  (rq.idx[CMD_OFS_W-1:0]),
      .pin_lvl (pin_lvl),
      .rd_data (rd_data),
      .in_en   (in_en),
      .out_en  (out_en),
      .out_lv  (out_lv)
   );

   for (genvar c = 0; c < NUM_PINS; c++) begin : g_adc
      assign adc_arr[c] = adc_result[c*ADC_BITS +: ADC_BITS];
   end

   assign rq_busy   = (rq.kind != RQ_NONE);
   assign chan_flag = in_en[rq.idx] | out_en[rq.idx];

   always_comb begin
      rsp_word = '0;
      case (rq.kind)
         RQ_REG: rsp_word[LANE_W-1:0] = rd_data;
         RQ_ADC: begin
            rsp_word[FLAG_POS]       = chan_flag;
            rsp_word[ADC_BITS-1:0]   = adc_arr[rq.idx];
         end
         default: ;
      endcase
   end

   smx_tx #(.FRAME_W(FRAME_W)) u_tx (
      .clk       (clk),
      .rst_n     (rst_n),
      .load      (sel_start),
      .load_word (rsp_word),
      .shift     (bit_fall),
      .clear     (sel_end),
      .miso      (spi_miso)
   );

   assign pin_out = out_lv;
   assign pin_oe  = out_en;

endmodule

// File: rtl/smx_checker.sv
module smx_checker #(
   parameter int NUM_PINS = 32
) (
   input logic                clk,
   input logic                rst_n,
   input logic                cs_n_s,
   input logic                miso,
   input logic                frame_done,
   input logic                wr_en,
   input logic                rq_busy,
   input logic [NUM_PINS-1:0] pin_oe,
   input logic [NUM_PINS-1:0] pin_out
);

   // R11
   miso_idle_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (cs_n_s && $past(cs_n_s)) |-> !miso);

   // R2
   pin_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
      !$past(wr_en) |-> ($stable(pin_oe) && $stable(pin_out)));

   // R9
   wr_src_chk: assert property (@(posedge clk) disable iff (!rst_n)
      wr_en |-> $past(frame_done));

   // R10
   rq_clear_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (rq_busy && frame_done) |=> !rq_busy);

   // R9
   done_pulse_chk: assert property (@(posedge clk) disable iff (!rst_n)
      frame_done |=> !frame_done);

   // R10
   no_wr_on_answer_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (rq_busy && frame_done) |=> !wr_en);

endmodule

bind spi_mux_target smx_checker #(.NUM_PINS(NUM_PINS)) u_smx_chk (
   .clk        (clk),
   .rst_n      (rst_n),
   .cs_n_s     (cs_n_s),
   .miso       (spi_miso),
   .frame_done (frame_done),
   .wr_en      (wr_en),
   .rq_busy    (rq_busy),
   .pin_oe     (pin_oe),
   .pin_out    (pin_out)
);

// File: tb/spi_mux_target_bench.sv
`timescale 1ns/1ps
module spi_mux_target_bench;

   localparam int NP   = 32;
   localparam int AB   = 12;
   localparam int HALF = 10;

   logic            clk = 1'b0;
   logic            rst_n = 1'b0;
   logic            sclk = 1'b0;
   logic            cs_n = 1'b1;
   logic            mosi = 1'b0;
   logic            miso;
   logic [NP*AB-1:0] adc = '0;
   logic [NP-1:0]   pins = '0;
   logic [NP-1:0]   pout, poe;

   int n_chk = 0;
   int n_fail = 0;

   logic [NP-1:0] m_in_en = '0, m_out_en = '0, m_out_lv = '0;

   always #5 clk = ~clk;

   spi_mux_target u_spi_mux_target (
      .clk        (clk),
      .rst_n      (rst_n),
      .spi_sclk   (sclk),
      .spi_cs_n   (cs_n),
      .spi_mosi   (mosi),
      .spi_miso   (miso),
      .adc_result (adc),
      .pin_in     (pins),
      .pin_out    (pout),
      .pin_oe     (poe)
   );

   function automatic logic [11:0] adc_of(input int ch);
      return 12'((ch * 291 + 7) & 12'hFFF);
   endfunction

   function automatic logic [7:0] m_reg(input int ofs);
      int base = 8 * (3 - (ofs & 3));
      logic [NP-1:0] v;
      case (ofs >> 2)
         0: v = pins & m_in_en;
         1: v = m_in_en;
         2: v = m_out_en;
         default: v = m_out_lv;
      endcase
      return v[base +: 8];
   endfunction

   task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
      n_chk++;
      if (act !== exp) begin
         n_fail++;
         $display("FAIL %s actual=%h expected=%h", req, act, exp);
      end
   endtask

   task automatic spi_frame(input logic [15:0] tx, input int nbits, output logic [15:0] rx);
      rx = '0;
      @(negedge clk);
      cs_n = 1'b0;
      repeat (HALF) @(negedge clk);
      for (int i = 0; i < nbits; i++) begin
         mosi = (i < 16) ? tx[15-i] : 1'b0;
         repeat (HALF) @(negedge clk);
         if (i < 16) rx = {rx[14:0], miso};
         sclk = 1'b1;
         repeat (HALF) @(negedge clk);
         sclk = 1'b0;
      end
      repeat (HALF) @(negedge clk);
      cs_n = 1'b1;
      mosi = 1'b0;
      repeat (12) @(negedge clk);
   endtask

   task automatic reg_wr(input int ofs, input logic [7:0] d);
      logic [15:0] rx;
      int base = 8 * (3 - (ofs & 3));
      spi_frame({8'(8'h20 | ofs), d}, 16, rx);
      case (ofs >> 2)
         1: m_in_en[base +: 8] = d;
         2: m_out_en[base +: 8] = d;
         3: m_out_lv[base +: 8] = d;
         default: ;
      endcase
   endtask

   task automatic reg_rd(input int ofs, output logic [15:0] rx);
      logic [15:0] dummy;
      spi_frame({8'(8'h30 | ofs), 8'h00}, 16, dummy);
      spi_frame(16'h0000, 16, rx);
   endtask

   task automatic adc_rd(input int ch, output logic [15:0] rx);
      logic [15:0] dummy;
      spi_frame({3'b000, 5'(ch), 8'h00}, 16, dummy);
      spi_frame(16'h0000, 16, rx);
   endtask

   function automatic logic [15:0] adc_exp(input int ch);
      logic f = m_in_en[ch] | m_out_en[ch];
      return {1'b0, f, 2'b00, adc_of(ch)};
   endfunction

   task automatic t_reset();
      logic [15:0] rx;
      chk("R1 pin_oe", 32'(poe), 32'h0);
      chk("R1 pin_out", 32'(pout), 32'h0);
      chk("R1 miso", 32'(miso), 32'h0);
      reg_rd(4'hA, rx);
      chk("R1 R4 out-enable reg after reset", 32'(rx), 32'h0);
      reg_rd(4'h5, rx);
      chk("R1 in-enable reg after reset", 32'(rx), 32'h0);
   endtask

   task automatic t_outputs();
      logic [15:0] rx;
      reg_wr(4'h8, 8'hA5);
      reg_wr(4'h9, 8'h3C);
      reg_wr(4'hA, 8'h0F);
      reg_wr(4'hB, 8'h81);
      chk("R2 R3 pin_oe lane order", 32'(poe), 32'hA53C0F81);
      reg_wr(4'hC, 8'h12);
      reg_wr(4'hD, 8'h34);
      reg_wr(4'hE, 8'h56);
      reg_wr(4'hF, 8'h78);
      chk("R2 R3 pin_out lane order", 32'(pout), 32'h12345678);
      reg_rd(4'h9, rx);
      chk("R4 read out-enable B0-7", 32'(rx), 32'h003C);
      reg_rd(4'hE, rx);
      chk("R4 read out-level A8-15", 32'(rx), 32'h0056);
   endtask

   task automatic t_inputs();
      logic [15:0] rx;
      pins = 32'hDEADBEEF;
      reg_wr(4'h4, 8'hF0);
      reg_wr(4'h7, 8'hFF);
      reg_rd(4'h0, rx);
      chk("R5 masked level B8-15", 32'(rx), 32'(m_reg(0)));
      reg_rd(4'h3, rx);
      chk("R5 level A0-7", 32'(rx), 32'h00EF);
      reg_rd(4'h1, rx);
      chk("R5 disabled lane reads zero", 32'(rx), 32'h0);
      reg_wr(4'h3, 8'h00);
      reg_rd(4'h3, rx);
      chk("R5 write to level reg ignored", 32'(rx), 32'h00EF);
      reg_rd(4'h4, rx);
      chk("R4 read in-enable B8-15", 32'(rx), 32'h00F0);
   endtask

   task automatic t_adc();
      logic [15:0] rx;
      int chans [6] = '{1, 9, 12, 17, 26, 30};
      foreach (chans[k]) begin
         adc_rd(chans[k], rx);
         chk($sformatf("R6 R7 R8 channel %0d", chans[k]), 32'(rx), 32'(adc_exp(chans[k])));
      end
      adc_rd(12, rx);
      chk("R8 flag clear on analog pin", 32'(rx[14]), 32'h0);
      reg_wr(4'h8, 8'h00);
      adc_rd(26, rx);
      chk("R8 flag drops after disable", 32'(rx), 32'(adc_exp(26)));
      adc_rd(0, rx);
      chk("R7 channel 0 slot", 32'(rx[11:0]), 32'(adc_of(0)));
      adc_rd(31, rx);
      chk("R7 channel 31 slot", 32'(rx[11:0]), 32'(adc_of(31)));
   endtask

   task automatic t_cut();
      logic [15:0] rx, dummy;
      spi_frame(16'h2FFF, 10, dummy);
      chk("R9 short write dropped", 32'(pout), 32'(m_out_lv));
      spi_frame(16'h2FFF, 17, dummy);
      chk("R9 long write dropped", 32'(pout), 32'(m_out_lv));
      spi_frame(16'h3B00, 16, dummy);
      spi_frame(16'h0000, 6, dummy);
      spi_frame(16'h0000, 16, rx);
      chk("R9 read survives short frame", 32'(rx), 32'(m_reg(4'hB)));
   endtask

   task automatic t_answer_mosi();
      logic [15:0] rx, dummy;
      spi_frame(16'h3D00, 16, dummy);
      spi_frame(16'h2CFF, 16, rx);
      chk("R10 answer frame data", 32'(rx), 32'(m_reg(4'hD)));
      chk("R10 answer frame MOSI not written", 32'(pout), 32'(m_out_lv));
      spi_frame(16'h2000, 16, rx);
      chk("R10 R11 no request left behind", 32'(rx), 32'h0);
   endtask

   task automatic t_idle();
      logic [15:0] rx;
      chk("R11 miso low while deselected", 32'(miso), 32'h0);
      spi_frame(16'h2000, 16, rx);
      chk("R11 idle frame returns zero", 32'(rx), 32'h0);
   endtask

   task automatic t_header();
      logic [15:0] rx, dummy;
      spi_frame(16'hACFF, 16, dummy);
      chk("R12 bit15 write ignored", 32'(pout), 32'(m_out_lv));
      spi_frame(16'h6CFF, 16, dummy);
      chk("R12 bit14 write ignored", 32'(pout), 32'(m_out_lv));
      spi_frame(16'h7300, 16, dummy);
      spi_frame(16'h2000, 16, rx);
      chk("R12 read with bad header ignored", 32'(rx), 32'h0);
   endtask

   initial begin
      for (int c = 0; c < NP; c++) adc[c*AB +: AB] = adc_of(c);
      repeat (5) @(negedge clk);
      rst_n = 1'b1;
      repeat (5) @(negedge clk);
      t_reset();
      t_outputs();
      t_inputs();
      t_adc();
      t_cut();
      t_answer_mosi();
      t_idle();
      t_header();
      $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
      $finish;
   end

   initial begin
      repeat (200000) @(posedge clk);
      n_fail++;
      $display("FAIL watchdog actual=running expected=finished");
      $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
      $finish;
   end

endmodule